// File: doc/BRIEF.md
# DRAM Access Timing Sequencer

This block turns a host memory request into the strobe and address timing a dynamic RAM array needs. It decides between host accesses and refresh cycles, drives the row strobe, the column strobe, a grant flag and an active-low acknowledge given as a data and output-enable pair. It also steers a 10-bit multiplexed address bus between the captured row address, the captured column address and a refresh address. Three static inputs tune the timing: the row address hold after the row strobe, the minimum precharge gap, and page mode, which keeps the row strobe low for as long as the host wants.

The block runs on a tick clock at twice the base rate, so one base cycle is two ticks. An internal phase bit marks alternate ticks as the rising (even) and falling (odd) base edges, counted from the first tick after reset. A refresh source outside the block supplies a level request and the refresh address. It drops its request when it sees the one-tick refresh acknowledge, which is also its cue to step its address counter. Host addresses must be stable for one tick before the latch enable goes high.

Top module: `dram_timing_seq`

## Requirements
- R1: After reset the block is idle: ras_n and cas_n high, gnt low, rfsh_ack low. req_n is sampled only on even ticks. An idle block with precharge met asserts ras_n low and gnt high on the even tick that samples req_n low, and ma shows the row address on that tick.
- R2: Between any two row-strobe assertions, ras_n stays high for at least 8 ticks when pre_sel is 0 and at least 6 ticks when pre_sel is 1. A host access waiting only on precharge starts exactly at that minimum.
- R3: During an access, ma switches from row to column address 2 ticks after ras_n falls when hold_sel is 0, and 1 tick after when hold_sel is 1.
- R4: cas_n falls 3 ticks after ras_n falls in every access, whatever hold_sel is. It rises on the even tick that samples req_n high.
- R5: With page_n high, ras_n stays low for exactly 8 ticks in an access.
- R6: With page_n low, ras_n stays low beyond 8 ticks. It rises on the first even tick, at least 8 ticks after it fell, that samples page_n high or req_n high. If req_n is the one sampled high, cas_n and gnt drop on the same tick.
- R7: ack_oe equals gnt AND NOT req_n, with no clock delay. ack_n_d goes low 8 ticks after ras_n falls in an access.
- R8: A refresh request is sampled only on odd ticks. When it is taken, ma shows rfsh_addr for one tick with ras_n high. ras_n is then low for exactly 8 ticks whatever page_n is, gnt and cas_n stay inactive, and rfsh_ack is high for the single tick on which ras_n rises.
- R9: When host and refresh requests are both pending, the one sampled first is served. The other starts once the first cycle and its precharge are complete: a waiting refresh takes its RAS at the precharge minimum, and so does a waiting access.
- R10: While ale_n is low, ma follows row_addr (and col_addr in the column phase) directly. While ale_n is high, the values captured on the last tick with ale_n low are used.
- R11: After ras_n rises in an access with req_n still low, gnt, cas_n, ack_n_d and the column address on ma hold until req_n is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the base rate |
| rst_n | input | 1 | Synchronous active-low reset |
| req_n | input | 1 | Host access request, active low |
| page_n | input | 1 | Page mode select, active low |
| hold_sel | input | 1 | Row hold: 0 = one base cycle, 1 = half cycle |
| pre_sel | input | 1 | Precharge: 0 = 4 base cycles, 1 = 3 base cycles |
| ale_n | input | 1 | Address latch enable, low = transparent |
| row_addr | input | 10 | Host row address |
| col_addr | input | 10 | Host column address |
| rfsh_req | input | 1 | Refresh request level from external refresh source |
| rfsh_addr | input | 10 | Refresh row address |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| gnt | output | 1 | Access grant, high during host cycles |
| ack_n_d | output | 1 | Acknowledge data, active low |
| ack_oe | output | 1 | Acknowledge output enable |
| ma | output | 10 | Multiplexed DRAM address |
| rfsh_ack | output | 1 | One-tick pulse at end of each refresh |

## Verification
The hardest situation to reach is a host request and a refresh request that both become pending in the same idle window. The winner then depends only on which tick parity comes first, and the loser must start exactly at the precharge minimum. The bench raises both requests together after aligning itself to an even or an odd next tick, for each precharge setting. It then counts the ticks from the rise of ras_n to the second strobe. A page-mode access that ends on request release is followed at once by a new request, which measures the exact host-side precharge gap as well.

// File: rtl/dram_seq_pkg.sv
`timescale 1ns/1ps
// Shared types for the DRAM access timing sequencer.
// Assumes: enums are only compared inside this block's modules.
package dram_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RWAIT,
        ST_RRAS,
        ST_ACC,
        ST_AHOLD
    } seq_state_t;

    typedef enum logic [1:0] {
        SEL_ROW,
        SEL_COL,
        SEL_RFSH
    } addr_sel_t;
endpackage

// File: rtl/dram_addr_hold.sv
`timescale 1ns/1ps
// Address capture stage: transparent while ale_n is low, holding while high.
// Assumes: the input is stable for one tick before ale_n rises, because the
// held copy is refreshed on clock ticks rather than by a level latch.
module dram_addr_hold #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ale_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] held;

    // Track the live address on every tick the latch is open.
    always_ff @(posedge clk) begin
        if (!rst_n)      held <= '0;
        else if (!ale_n) held <= d;
    end

    // Open latch passes the input straight through.
    assign q = ale_n ? held : d;
endmodule

// File: rtl/dram_pre_timer.sv
`timescale 1ns/1ps
// Precharge timer: counts ticks of row strobe high and reports when a host
// access (next tick) or a refresh (one tick later) may assert the strobe.
// Assumes: pre_sel only changes while the strobe is high and the block idle.
module dram_pre_timer #(
    parameter int PRE_LONG  = 4,
    parameter int PRE_SHORT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    input  logic pre_sel,
    output logic acc_ok,
    output logic rf_ok
);
    localparam int CMAX = 2 * PRE_LONG;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] CNT_TOP  = CW'(CMAX);
    localparam logic [CW-1:0] ACC_LONG = CW'(2 * PRE_LONG - 1);
    localparam logic [CW-1:0] ACC_SHRT = CW'(2 * PRE_SHORT - 1);
    localparam logic [CW-1:0] RF_LONG  = CW'(2 * PRE_LONG - 2);
    localparam logic [CW-1:0] RF_SHRT  = CW'(2 * PRE_SHORT - 2);

    logic [CW-1:0] cnt;
    logic [CW-1:0] acc_need;
    logic [CW-1:0] rf_need;

    // Count strobe-high ticks, saturating, cleared while the strobe is low.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= CNT_TOP;
        else if (!ras_n)      cnt <= '0;
        else if (cnt < CNT_TOP) cnt <= cnt + 1'b1;
    end

    // Pick thresholds from the precharge select.
    always_comb begin
        acc_need = pre_sel ? ACC_SHRT : ACC_LONG;
        rf_need  = pre_sel ? RF_SHRT  : RF_LONG;
    end

    assign acc_ok = (cnt >= acc_need);
    assign rf_ok  = (cnt >= rf_need);

    // R2
    ras_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> ($past(cnt) >= $past(acc_need)));
endmodule

// File: rtl/dram_seq_fsm.sv
`timescale 1ns/1ps
// Cycle sequencer: arbitrates host (even ticks) against refresh (odd ticks),
// runs the access and refresh strobe timing and selects the address source.
// Assumes: hold_sel is static during an access; rfsh_req stays high until
// rfsh_ack is seen.
module dram_seq_fsm
    import dram_seq_pkg::*;
#(
    parameter int RAS_CYC    = 4,
    parameter int ACK_CYC    = 4,
    parameter int CAS_TICKS  = 3,
    parameter int HOLD_LONG  = 2,
    parameter int HOLD_SHORT = 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_n,
    input  logic      rfsh_req,
    input  logic      page_n,
    input  logic      hold_sel,
    input  logic      acc_ok,
    input  logic      rf_ok,
    output logic      ras_n,
    output logic      cas_n,
    output logic      gnt,
    output logic      ack_low,
    output addr_sel_t sel,
    output logic      rfsh_ack
);
    localparam int RAS_T  = 2 * RAS_CYC;
    localparam int ACK_T  = 2 * ACK_CYC;
    localparam int TMAX0  = (RAS_T > ACK_T) ? RAS_T : ACK_T;
    localparam int TMAX   = (TMAX0 > CAS_TICKS) ? TMAX0 : CAS_TICKS;
    localparam int TW     = $clog2(TMAX + 1);
    localparam logic [TW-1:0] TC_TOP   = TW'(TMAX);
    localparam logic [TW-1:0] RAS_END  = TW'(RAS_T - 1);
    localparam logic [TW-1:0] ACK_AT   = TW'(ACK_T);
    localparam logic [TW-1:0] CAS_AT   = TW'(CAS_TICKS);
    localparam logic [TW-1:0] HOLD_L   = TW'(HOLD_LONG);
    localparam logic [TW-1:0] HOLD_S   = TW'(HOLD_SHORT);

    seq_state_t    state;
    logic          ph;
    logic [TW-1:0] tc;
    logic          in_acc;

    // Phase bit: 0 marks the even (rising base) tick, 1 the odd tick.
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= 1'b0;
        else        ph <= ~ph;
    end

    // Main state register, tick counter and refresh completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            tc       <= '0;
            rfsh_ack <= 1'b0;
        end else begin
            rfsh_ack <= 1'b0;
            if (state != ST_IDLE && state != ST_RWAIT && tc < TC_TOP)
                tc <= tc + 1'b1;
            case (state)
                ST_IDLE: begin
                    if (!ph && !req_n && acc_ok) begin
                        state <= ST_ACC;
                        tc    <= '0;
                    end else if (ph && rfsh_req && rf_ok) begin
                        state <= ST_RWAIT;
                    end
                end
                ST_RWAIT: begin
                    state <= ST_RRAS;
                    tc    <= '0;
                end
                ST_RRAS: begin
                    if (tc == RAS_END) begin
                        state    <= ST_IDLE;
                        rfsh_ack <= 1'b1;
                    end
                end
                ST_ACC: begin
                    if (!ph && tc >= RAS_END) begin
                        if (req_n)       state <= ST_IDLE;
                        else if (page_n) state <= ST_AHOLD;
                    end
                end
                ST_AHOLD: begin
                    if (!ph && req_n) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Strobes, grant and acknowledge decoded from state and tick count.
    always_comb begin
        in_acc  = (state == ST_ACC) || (state == ST_AHOLD);
        ras_n   = !((state == ST_ACC) || (state == ST_RRAS));
        gnt     = in_acc;
        cas_n   = !(in_acc && tc >= CAS_AT);
        ack_low = in_acc && tc >= ACK_AT;
    end

    // Address source selection with the row hold option.
    always_comb begin
        if (state == ST_RWAIT || state == ST_RRAS)
            sel = SEL_RFSH;
        else if (in_acc && tc >= (hold_sel ? HOLD_S : HOLD_L))
            sel = SEL_COL;
        else
            sel = SEL_ROW;
    end

    // R5
    ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> ($past(tc) >= RAS_END));

    // R8
    rfsh_sample_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RWAIT) |-> !ph);
endmodule

// File: rtl/dram_timing_seq.sv
`timescale 1ns/1ps
// DRAM access timing sequencer top: address capture, precharge timer,
// cycle sequencer and the multiplexed address output.
// Assumes: clk runs at twice the DRAM base rate; refresh request generation
// and the refresh address counter live outside this block.
module dram_timing_seq
    import dram_seq_pkg::*;
#(
    parameter int AW         = 10,
    parameter int RAS_CYC    = 4,
    parameter int ACK_CYC    = 4,
    parameter int CAS_TICKS  = 3,
    parameter int HOLD_LONG  = 2,
    parameter int HOLD_SHORT = 1,
    parameter int PRE_LONG   = 4,
    parameter int PRE_SHORT  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_n,
    input  logic          page_n,
    input  logic          hold_sel,
    input  logic          pre_sel,
    input  logic          ale_n,
    input  logic [AW-1:0] row_addr,
    input  logic [AW-1:0] col_addr,
    input  logic          rfsh_req,
    input  logic [AW-1:0] rfsh_addr,
    output logic          ras_n,
    output logic          cas_n,
    output logic          gnt,
    output logic          ack_n_d,
    output logic          ack_oe,
    output logic [AW-1:0] ma,
    output logic          rfsh_ack
);
    logic [AW-1:0] row_q;
    logic [AW-1:0] col_q;
    logic          acc_ok;
    logic          rf_ok;
    logic          ack_low;
    addr_sel_t     sel;

    dram_addr_hold #(.W(AW)) u_row (
        .clk(clk), .rst_n(rst_n), .ale_n(ale_n), .d(row_addr), .q(row_q));

    dram_addr_hold #(.W(AW)) u_col (
        .clk(clk), .rst_n(rst_n), .ale_n(ale_n), .d(col_addr), .q(col_q));

    dram_pre_timer #(.PRE_LONG(PRE_LONG), .PRE_SHORT(PRE_SHORT)) u_pre (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .pre_sel(pre_sel),
        .acc_ok(acc_ok), .rf_ok(rf_ok));

    dram_seq_fsm #(
        .RAS_CYC(RAS_CYC), .ACK_CYC(ACK_CYC), .CAS_TICKS(CAS_TICKS),
        .HOLD_LONG(HOLD_LONG), .HOLD_SHORT(HOLD_SHORT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .rfsh_req(rfsh_req),
        .page_n(page_n), .hold_sel(hold_sel), .acc_ok(acc_ok), .rf_ok(rf_ok),
        .ras_n(ras_n), .cas_n(cas_n), .gnt(gnt), .ack_low(ack_low),
        .sel(sel), .rfsh_ack(rfsh_ack));

    // Drive the DRAM address from the selected source.
    always_comb begin
        case (sel)
            SEL_COL:  ma = col_q;
            SEL_RFSH: ma = rfsh_addr;
            default:  ma = row_q;
        endcase
    end

    // Acknowledge is only driven while the host holds its request.
    assign ack_n_d = !ack_low;
    assign ack_oe  = gnt && !req_n;

    // R1
    grant_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt) |-> (!ras_n && $past(!req_n)));

    // R4
    cas_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> (gnt && !ras_n && $past(gnt, 3) && !$past(gnt, 4)));

    // R3
    col_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && gnt && hold_sel) |=> (sel == SEL_COL));

    // R8
    rfsh_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_ack |-> (!gnt && ras_n && $past(!ras_n)));

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_n && $past(ale_n) && sel == SEL_ROW && $past(sel) == SEL_ROW)
            |-> $stable(ma));
endmodule

// File: tb/test_dram_timing_seq.sv
`timescale 1ns/1ps
module test_dram_timing_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_n = 1'b1;
    logic       page_n = 1'b1;
    logic       hold_sel = 1'b0;
    logic       pre_sel = 1'b0;
    logic       ale_n = 1'b0;
    logic [9:0] row_addr = '0;
    logic [9:0] col_addr = '0;
    logic       rfsh_req = 1'b0;
    logic [9:0] rfsh_addr = '0;
    logic       ras_n, cas_n, gnt, ack_n_d, ack_oe, rfsh_ack;
    logic [9:0] ma;

    int vectors = 0;
    int miscompares = 0;
    int tk = 0;

    always #5 clk = ~clk;

    dram_timing_seq i_dram_timing_seq (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .page_n(page_n),
        .hold_sel(hold_sel), .pre_sel(pre_sel), .ale_n(ale_n),
        .row_addr(row_addr), .col_addr(col_addr), .rfsh_req(rfsh_req),
        .rfsh_addr(rfsh_addr), .ras_n(ras_n), .cas_n(cas_n), .gnt(gnt),
        .ack_n_d(ack_n_d), .ack_oe(ack_oe), .ma(ma), .rfsh_ack(rfsh_ack));

    // Bench tick index: ticks since reset release.
    always @(posedge clk) if (rst_n) tk <= tk + 1;

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d (tick %0d)", tag, act, exp, tk);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    // R2 monitor: strobe-high gap before every assertion.
    int  rise_tk = 0;
    bit  have_rise = 0;
    logic prev_ras = 1'b1;
    always @(posedge clk) begin
        #2;
        if (!rst_n) begin
            prev_ras = 1'b1;
            have_rise = 0;
        end else begin
            if (prev_ras && !ras_n && have_rise) begin
                vectors++;
                if (tk - rise_tk < (pre_sel ? 6 : 8)) begin
                    miscompares++;
                    $display("FAIL R2 gap: actual %0d expected >= %0d",
                             tk - rise_tk, pre_sel ? 6 : 8);
                end
            end
            if (!prev_ras && ras_n) begin
                rise_tk = tk;
                have_rise = 1;
            end
            prev_ras = ras_n;
        end
    end

    // Host access; pext = extra base cycles of page mode (0 = page off).
    task automatic run_access(input logic [9:0] r, input logic [9:0] c,
                              input int pext, input bit keep_addr);
        if (!keep_addr) begin
            row_addr = r; col_addr = c; ale_n = 1'b0;
        end
        page_n = (pext > 0) ? 1'b0 : 1'b1;
        req_n = 1'b0;
        if (tk % 2 != 0) begin
            step(1);
            chk("R1 odd tick ignores req ras_n", ras_n, 1);
            chk("R1 odd tick ignores req gnt", gnt, 0);
        end
        step(1);
        chk("R1 ras_n at start", ras_n, 0);
        chk("R1 gnt at start", gnt, 1);
        chk("R1 row on ma", ma, r);
        chk("R4 cas_n high at start", cas_n, 1);
        chk("R7 ack_oe while granted", ack_oe, 1);
        chk("R7 ack_n_d high early", ack_n_d, 1);
        step(1);
        chk("R3 ma one tick after ras", ma, hold_sel ? c : r);
        step(1);
        chk("R3 ma two ticks after ras", ma, c);
        chk("R4 cas_n still high", cas_n, 1);
        step(1);
        chk("R4 cas_n low three ticks after", cas_n, 0);
        step(4);
        chk("R5 ras_n low at tick 7", ras_n, 0);
        chk("R7 ack_n_d high at tick 7", ack_n_d, 1);
        step(1);
        chk("R7 ack_n_d low at tick 8", ack_n_d, 0);
        if (pext == 0) begin
            chk("R5 ras_n high at tick 8", ras_n, 1);
            chk("R11 gnt held", gnt, 1);
            chk("R11 cas_n held", cas_n, 0);
        end else begin
            chk("R6 ras_n held in page", ras_n, 0);
            step(2 * pext);
            chk("R6 ras_n still held", ras_n, 0);
            page_n = 1'b1;
            step(1);
            chk("R6 page release waits even tick", ras_n, 0);
            step(1);
            chk("R6 ras_n rises after page release", ras_n, 1);
            chk("R11 gnt after page release", gnt, 1);
        end
        step(2);
        chk("R11 gnt hold", gnt, 1);
        chk("R11 cas_n hold", cas_n, 0);
        chk("R11 ack_n_d hold", ack_n_d, 0);
        chk("R11 column hold on ma", ma, c);
        req_n = 1'b1;
        #1;
        chk("R7 ack_oe drops with req", ack_oe, 0);
        step(1);
        chk("R4 cas_n waits even tick", cas_n, 0);
        step(1);
        chk("R4 cas_n rises on release", cas_n, 1);
        chk("R11 gnt drops on release", gnt, 0);
        chk("R1 row back on ma", ma, r);
        step(10);
    endtask

    // Page access ended by request release, followed at once by a new one.
    task automatic prech_test(input bit ps);
        int n2;
        n2 = ps ? 6 : 8;
        pre_sel = ps;
        step(10);
        if (tk % 2 != 0) step(1);
        row_addr = 10'h155; col_addr = 10'h0AA; ale_n = 1'b0;
        page_n = 1'b0; req_n = 1'b0;
        step(1);
        chk("R6 page access start", ras_n, 0);
        step(10);
        req_n = 1'b1;
        step(1);
        chk("R6 release waits even tick", ras_n, 0);
        step(1);
        chk("R6 ras_n rises on req release", ras_n, 1);
        chk("R6 cas_n rises with ras", cas_n, 1);
        chk("R6 gnt drops with ras", gnt, 0);
        req_n = 1'b0; page_n = 1'b1;
        step(n2 - 1);
        chk("R2 still precharging", ras_n, 1);
        step(1);
        chk("R2 ras_n at exact minimum", ras_n, 0);
        chk("R2 gnt at exact minimum", gnt, 1);
        step(8);
        req_n = 1'b1;
        step(2);
        chk("R4 access closed", gnt, 0);
        step(10);
    endtask

    task automatic refresh_test(input logic [9:0] a, input bit ps, input bit odd_next);
        pre_sel = ps;
        page_n = 1'b0;
        step(10);
        if ((tk % 2 != 0) != odd_next) step(1);
        rfsh_addr = a; rfsh_req = 1'b1;
        if (tk % 2 == 0) begin
            step(1);
            chk("R8 even tick ignores refresh", ma, row_addr);
        end
        step(1);
        chk("R8 refresh address before ras", ma, a);
        chk("R8 ras_n high before refresh", ras_n, 1);
        chk("R8 gnt low", gnt, 0);
        step(1);
        chk("R8 ras_n low in refresh", ras_n, 0);
        chk("R8 refresh address held", ma, a);
        step(3);
        chk("R8 cas_n idle in refresh", cas_n, 1);
        chk("R8 gnt idle in refresh", gnt, 0);
        step(4);
        chk("R8 ras_n low at tick 7", ras_n, 0);
        chk("R8 no early ack", rfsh_ack, 0);
        step(1);
        chk("R8 ras_n rises at tick 8", ras_n, 1);
        chk("R8 rfsh_ack pulse", rfsh_ack, 1);
        rfsh_req = 1'b0;
        step(1);
        chk("R8 rfsh_ack one tick", rfsh_ack, 0);
        page_n = 1'b1;
        step(10);
    endtask

    task automatic arb_test(input bit ps, input bit acc_first);
        int n2;
        n2 = ps ? 6 : 8;
        pre_sel = ps;
        page_n = 1'b1;
        step(10);
        if ((tk % 2 == 0) != acc_first) step(1);
        row_addr = 10'h3C3; col_addr = 10'h03C; ale_n = 1'b0;
        rfsh_addr = 10'h2F0;
        req_n = 1'b0; rfsh_req = 1'b1;
        step(1);
        if (acc_first) begin
            chk("R9 access first gnt", gnt, 1);
            chk("R9 access first ras", ras_n, 0);
            step(8);
            chk("R9 access ras ends", ras_n, 1);
            req_n = 1'b1;
            step(n2 - 1);
            chk("R9 refresh waits precharge", ras_n, 1);
            chk("R9 refresh address placed", ma, 10'h2F0);
            step(1);
            chk("R9 refresh ras at minimum", ras_n, 0);
            chk("R9 refresh gnt low", gnt, 0);
            step(8);
            chk("R9 refresh done", rfsh_ack, 1);
            rfsh_req = 1'b0;
        end else begin
            chk("R9 refresh first addr", ma, 10'h2F0);
            chk("R9 refresh first gnt", gnt, 0);
            step(1);
            chk("R9 refresh first ras", ras_n, 0);
            chk("R9 access held off", gnt, 0);
            step(8);
            chk("R9 refresh done", rfsh_ack, 1);
            rfsh_req = 1'b0;
            step(n2 - 1);
            chk("R9 access waits precharge", gnt, 0);
            step(1);
            chk("R9 access at minimum gnt", gnt, 1);
            chk("R9 access at minimum ras", ras_n, 0);
            step(8);
            req_n = 1'b1;
            step(2);
            chk("R9 access closed", gnt, 0);
        end
        step(10);
    endtask

    initial begin
        #1_000_000;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        step(4);
        chk("R1 reset ras_n", ras_n, 1);
        chk("R1 reset cas_n", cas_n, 1);
        chk("R1 reset gnt", gnt, 0);
        chk("R1 reset rfsh_ack", rfsh_ack, 0);
        rst_n = 1'b1;
        step(12);
        for (int ps = 0; ps < 2; ps++) begin
            for (int hs = 0; hs < 2; hs++) begin
                for (int pe = 0; pe < 3; pe++) begin
                    for (int al = 0; al < 2; al++) begin
                        pre_sel = ps[0];
                        hold_sel = hs[0];
                        if (al == 1) step(1);
                        run_access(10'(37 * (ps * 12 + hs * 6 + pe * 2 + al) + 5),
                                   10'(1023 - 29 * (pe + 3 * hs + 6 * ps)),
                                   (pe == 0) ? 0 : 2 * pe - 1, 1'b0);
                    end
                end
            end
        end
        for (int ps = 0; ps < 2; ps++) prech_test(ps[0]);
        for (int ps = 0; ps < 2; ps++) begin
            refresh_test(10'(100 + ps), ps[0], 1'b1);
            refresh_test(10'(700 + ps), ps[0], 1'b0);
        end
        for (int ps = 0; ps < 2; ps++) begin
            arb_test(ps[0], 1'b1);
            arb_test(ps[0], 1'b0);
        end
        // R10: transparent then held addresses.
        hold_sel = 1'b0;
        ale_n = 1'b0; row_addr = 10'h21A; col_addr = 10'h19B;
        #1;
        chk("R10 transparent row", ma, 10'h21A);
        step(1);
        ale_n = 1'b1; row_addr = 10'h1E5; col_addr = 10'h264;
        #1;
        chk("R10 held row", ma, 10'h21A);
        run_access(10'h21A, 10'h19B, 0, 1'b1);
        ale_n = 1'b0;
        #1;
        chk("R10 transparent again", ma, 10'h1E5);
        step(4);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule